// File: doc/BRIEF.md
# Serial receive port conditioner

This block is the front end of one serial receive port. It takes three slow asynchronous inputs: a line clock, a serial data line and a frame sync line. Each input passes through a two-flop synchronizer into the system clock domain, and the line clock is then edge-detected. Separate control inputs invert the clock, the data and the sync. Inverting the clock moves sampling from the rising line-clock edge to the falling edge.

Each recovered bit appears as a one-cycle strobe, together with the bit value, its position in the frame and a start-of-frame flag. The frame sync may arrive up to two line clocks ahead of the first bit of the frame. A two-bit delay setting tells the block how early it comes, and the block moves the frame origin to the right bit. In unchannelized mode the sync line is ignored and the stream is one flat channel.

A separate one-shot output resets an external loopback-pattern detector. It fires when software drives the detector-reset control high and then low again.

Top module: `rx_port_frontend`

## Requirements
- R1: While rst_n is low, and until the first recovered bit, bit_vld, frame_start and det_rst_pulse are 0 and bit_idx is 0.
- R2: With cfg_clk_inv = 0 a bit is recovered on each rising line_clk edge; with cfg_clk_inv = 1 a bit is recovered on each falling edge. There is exactly one bit_vld strobe per line clock period.
- R3: With cfg_data_inv = 1, bit_data is the complement of the line_data level at the sampling edge; with 0 it equals that level.
- R4: With cfg_sync_inv = 0 the sync is active when line_sync is high; with cfg_sync_inv = 1 it is active when line_sync is low.
- R5: cfg_sync_dly = 2'b00: the bit sampled on the same edge as an active sync gets bit_idx 0.
- R6: cfg_sync_dly = 2'b10 gives bit_idx 0 to the bit one sampling edge after the active sync. cfg_sync_dly = 2'b11 gives bit_idx 0 to the bit two sampling edges after it.
- R7: cfg_sync_dly = 2'b01: a sync that is active on the opposite (non-sampling) line clock edge gives bit_idx 0 to the bit on the next sampling edge.
- R8: Without a sync, bit_idx counts up by one per bit and wraps from FRAME_LEN-1 to 0. frame_start is high exactly on the strobes with bit_idx 0. The first bit after reset has bit_idx 0.
- R9: With cfg_unchan = 1 the sync line and cfg_sync_dly are ignored: every strobe carries bit_idx 0 and frame_start 0.
- R10: det_rst_pulse is high for exactly one system cycle, two cycles after the cycle in which cfg_det_rst is sampled 1 and then 0. A rising cfg_det_rst produces no pulse.
- R11: bit_vld rises on the third system clock edge after a sampling line-clock edge reaches the input. bit_data and bit_idx change only with bit_vld. Two strobes never occur in adjacent cycles. The system clock must be at least four times the line clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_clk | input | 1 | Asynchronous line clock |
| line_data | input | 1 | Asynchronous serial data |
| line_sync | input | 1 | Asynchronous frame sync |
| cfg_clk_inv | input | 1 | 1 = sample on falling line clock edge |
| cfg_data_inv | input | 1 | 1 = complement received data |
| cfg_sync_inv | input | 1 | 1 = sync active low |
| cfg_sync_dly | input | 2 | How early sync arrives: 00 none, 01 half clock, 10 one clock, 11 two clocks |
| cfg_unchan | input | 1 | 1 = ignore sync, flat channel |
| cfg_det_rst | input | 1 | Detector-reset control bit |
| bit_vld | output | 1 | One-cycle strobe per recovered bit |
| bit_data | output | 1 | Recovered bit |
| bit_idx | output | IDX_W | Position of the bit in the frame |
| frame_start | output | 1 | High with the strobe of bit 0 |
| det_rst_pulse | output | 1 | One-shot reset for the pattern detector |

## Verification
The assertions check several properties on every cycle: strobes are never adjacent, outputs hold between strobes, frame_start appears only with index 0, the index stays in range, unchannelized mode keeps the index flat, and the detector pulse is a one-shot that only a 1-then-0 control history can cause. The frame origin for each of the four sync delays, the data, clock and sync polarities, and the exact strobe latency can only be shown by the bench. It drives framed line traffic and compares every strobe, and every cycle without one, against a behavioural model of those settings.

// File: rtl/rx_port_frontend.sv
module rx_port_frontend #(
  parameter int FRAME_LEN = 193,
  localparam int IDX_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_clk,
  input  logic             line_data,
  input  logic             line_sync,
  input  logic             cfg_clk_inv,
  input  logic             cfg_data_inv,
  input  logic             cfg_sync_inv,
  input  logic [1:0]       cfg_sync_dly,
  input  logic             cfg_unchan,
  input  logic             cfg_det_rst,
  output logic             bit_vld,
  output logic             bit_data,
  output logic [IDX_W-1:0] bit_idx,
  output logic             frame_start,
  output logic             det_rst_pulse
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic [2:0] meta, syncd;
  logic clk_prev;
  logic sync_d1, sync_d2, sync_half;
  logic det_prev;
  logic zero_now;
  logic [IDX_W-1:0] cnt, next_idx;

  wire rise        = syncd[2] & ~clk_prev;
  wire fall        = ~syncd[2] & clk_prev;
  wire sample_edge = cfg_clk_inv ? fall : rise;
  wire half_edge   = cfg_clk_inv ? rise : fall;
  wire data_eff    = syncd[1] ^ cfg_data_inv;
  wire sync_eff    = syncd[0] ^ cfg_sync_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta     <= '0;
      syncd    <= '0;
      clk_prev <= 1'b0;
    end else begin
      meta     <= {line_clk, line_data, line_sync};
      syncd    <= meta;
      clk_prev <= syncd[2];
    end
  end

  always_comb begin
    unique case (cfg_sync_dly)
      2'b00:   zero_now = sync_eff;
      2'b01:   zero_now = sync_half;
      2'b10:   zero_now = sync_d1;
      default: zero_now = sync_d2;
    endcase
    if (cfg_unchan)
      zero_now = 1'b0;
  end

  assign next_idx = (zero_now || cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_d1   <= 1'b0;
      sync_d2   <= 1'b0;
      sync_half <= 1'b0;
    end else begin
      if (sample_edge) begin
        sync_d1 <= sync_eff;
        sync_d2 <= sync_d1;
      end
      if (half_edge)
        sync_half <= sync_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= LAST;
      bit_vld     <= 1'b0;
      bit_data    <= 1'b0;
      bit_idx     <= '0;
      frame_start <= 1'b0;
    end else begin
      bit_vld     <= sample_edge;
      frame_start <= sample_edge && !cfg_unchan && next_idx == '0;
      if (sample_edge) begin
        cnt      <= next_idx;
        bit_data <= data_eff;
        bit_idx  <= cfg_unchan ? '0 : next_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_prev      <= 1'b0;
      det_rst_pulse <= 1'b0;
    end else begin
      det_prev      <= cfg_det_rst;
      det_rst_pulse <= det_prev & ~cfg_det_rst;
    end
  end

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld); // R11
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |-> $stable(bit_data) && $stable(bit_idx)); // R11
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= LAST); // R8
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> bit_vld && bit_idx == '0); // R8
  AST_UNCHAN_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_unchan) |-> !frame_start && (!bit_vld || bit_idx == '0)); // R9
  AST_DET_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    det_rst_pulse |=> !det_rst_pulse); // R10
  AST_DET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    det_rst_pulse |-> !$past(cfg_det_rst) && $past(cfg_det_rst, 2)); // R10

endmodule

// File: tb/test_rx_port_frontend.sv
`timescale 1ns/1ps
module test_rx_port_frontend;
  localparam int LEN = 12;
  localparam int W = $clog2(LEN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_clk = 1'b0, line_data = 1'b0, line_sync = 1'b0;
  logic cfg_clk_inv = 1'b0, cfg_data_inv = 1'b0, cfg_sync_inv = 1'b0;
  logic [1:0] cfg_sync_dly = 2'b00;
  logic cfg_unchan = 1'b0, cfg_det_rst = 1'b0;
  logic bit_vld, bit_data, frame_start, det_rst_pulse;
  logic [W-1:0] bit_idx;

  rx_port_frontend #(.FRAME_LEN(LEN)) i_rx_port_frontend (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_data(line_data),
    .line_sync(line_sync), .cfg_clk_inv(cfg_clk_inv), .cfg_data_inv(cfg_data_inv),
    .cfg_sync_inv(cfg_sync_inv), .cfg_sync_dly(cfg_sync_dly), .cfg_unchan(cfg_unchan),
    .cfg_det_rst(cfg_det_rst), .bit_vld(bit_vld), .bit_data(bit_data),
    .bit_idx(bit_idx), .frame_start(frame_start), .det_rst_pulse(det_rst_pulse));

  always #2 clk = ~clk;

  typedef struct { int t; bit d; int idx; bit fs; } ev_t;
  ev_t q[$];
  int now = 0, vectors = 0, miscompares = 0;
  bit det_last = 1'b0;
  bit done = 1'b0;
  string tag = "R1";
  bit dbit[64], full[64], half[64], st[64];

  task automatic fail(string req, string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0d expected %0d (tick %0d)", req, what, act, exp, now);
  endtask

  task automatic tick();
    bit exp_pulse;
    @(negedge clk);
    now++;
    vectors++;
    if (q.size() > 0 && q[0].t == now) begin
      ev_t e = q.pop_front();
      if (bit_vld !== 1'b1) fail({tag, " R11"}, "bit_vld", int'(bit_vld), 1);
      if (bit_data !== e.d) fail({tag, " R2 R3"}, "bit_data", int'(bit_data), int'(e.d));
      if (int'(bit_idx) != e.idx) fail({tag, " R8"}, "bit_idx", int'(bit_idx), e.idx);
      if (frame_start !== e.fs) fail({tag, " R8"}, "frame_start", int'(frame_start), int'(e.fs));
    end else begin
      if (bit_vld !== 1'b0) fail({tag, " R11"}, "stray bit_vld", int'(bit_vld), 0);
      if (frame_start !== 1'b0) fail({tag, " R8"}, "stray frame_start", int'(frame_start), 0);
    end
    exp_pulse = rst_n && det_last && !cfg_det_rst;
    if (det_rst_pulse !== exp_pulse) fail("R10", "det_rst_pulse", int'(det_rst_pulse), int'(exp_pulse));
    det_last = cfg_det_rst;
  endtask

  task automatic scenario(string t_tag, bit cinv, bit dinv, bit sinv, bit [1:0] dly,
                          bit unch, int nbits, int per, int off, int seed);
    int m = LEN - 1;
    tag = t_tag;
    for (int j = 0; j < 64; j++) begin
      dbit[j] = 1'(((j * 37 + seed) >> 1) & 1);
      st[j] = (j < nbits) && (per > 0) && (j >= off) && ((j - off) % per == 0);
      full[j] = 1'b0;
      half[j] = 1'b0;
    end
    for (int j = 2; j < nbits; j++)
      if (st[j])
        case (dly)
          2'b00: full[j] = 1'b1;
          2'b01: half[j] = 1'b1;
          2'b10: full[j-1] = 1'b1;
          default: full[j-2] = 1'b1;
        endcase
    cfg_clk_inv = cinv; cfg_data_inv = dinv; cfg_sync_inv = sinv;
    cfg_sync_dly = dly; cfg_unchan = unch;
    line_clk = cinv; line_data = dinv; line_sync = sinv;
    rst_n = 1'b0;
    repeat (4) tick();
    if (bit_idx !== '0) fail("R1", "bit_idx in reset", int'(bit_idx), 0);
    if (bit_vld !== 1'b0) fail("R1", "bit_vld in reset", int'(bit_vld), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    line_data = dbit[0] ^ dinv;
    line_sync = full[0] ^ sinv;
    repeat (2) tick();
    for (int j = 0; j < nbits; j++) begin
      for (int p = 0; p < 8; p++) begin
        tick();
        case (p)
          0: begin
            ev_t e;
            line_clk = ~cinv;
            if (unch) m = 0;
            else if (st[j]) m = 0;
            else m = (m == LEN - 1) ? 0 : m + 1;
            e.t = now + 3; e.d = dbit[j]; e.idx = unch ? 0 : m; e.fs = !unch && m == 0;
            q.push_back(e);
          end
          2: line_sync = ((j + 1 < nbits) ? half[j+1] : 1'b0) ^ sinv;
          4: line_clk = cinv;
          6: begin
            line_data = ((j + 1 < nbits) ? dbit[j+1] : 1'b0) ^ dinv;
            line_sync = ((j + 1 < nbits) ? full[j+1] : 1'b0) ^ sinv;
          end
          default: ;
        endcase
      end
    end
    repeat (6) tick();
    vectors++;
    if (q.size() != 0) begin
      fail({tag, " R11"}, "strobes missing", 0, q.size());
      q.delete();
    end
  endtask

  initial begin
    scenario("R2 R5 R8", 0, 0, 0, 2'b00, 0, 30, 12, 3, 1);
    scenario("R8 wrap", 0, 0, 0, 2'b00, 0, 30, 100, 2, 5);
    scenario("R2 R3 R6 dly11", 1, 1, 0, 2'b11, 0, 30, 9, 4, 2);
    scenario("R4 R6 dly10", 0, 0, 1, 2'b10, 0, 30, 7, 3, 3);
    scenario("R7 half", 0, 0, 0, 2'b01, 0, 30, 9, 2, 4);
    scenario("R7 R4 half inv", 1, 0, 1, 2'b01, 0, 30, 8, 3, 6);
    scenario("R9 unchan", 0, 1, 0, 2'b00, 1, 24, 5, 2, 7);
    scenario("R9 unchan dly11", 1, 0, 1, 2'b11, 1, 20, 4, 2, 8);
    tag = "R10";
    repeat (3) tick();
    cfg_det_rst = 1'b1; repeat (4) tick();
    cfg_det_rst = 1'b0; repeat (5) tick();
    cfg_det_rst = 1'b1; tick();
    cfg_det_rst = 1'b0; repeat (5) tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule